// File: doc/BRIEF.md
# Single-Digit Calculator Sequencer

This block turns a stream of already debounced key codes into a two-operand decimal calculation. It expects keys in a fixed order: a first digit, an operator, a second digit and then the equals key. It keeps the operands and the chosen operation, and produces one 8-bit binary value for a two-digit display.

The display value follows the entry. It shows the first operand once that digit is taken and the second operand once that digit is taken. After equals it shows the sum, difference or product. A key that does not fit the current step is dropped, and the block stays where it was. Once a result is shown, the next digit key starts a new calculation.

Keys arrive on a valid/ready stream. The block accepts a key on every clock edge where `key_valid` and `key_ready` are both high. `key_ready` is low while reset is held and during the first cycle after reset is released. After that it stays high, so the block never applies back-pressure. A key that is not taken must be held by the source until it is. The display output is a plain registered value with no handshake.

Top module: `digit_calc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `disp_value` becomes 0 and the block returns to the first-digit step. An equals key sent right after reset leaves the display at 0.
- R2: In the first-digit step, an accepted key code from 0 to 9 becomes the first operand. `disp_value` equals that digit from the cycle after acceptance.
- R3: In the operator step, code 10 (add), code 11 (subtract) or code 12 (multiply) is stored as the operation. `disp_value` does not change.
- R4: In the second-digit step, an accepted digit code from 0 to 9 becomes the second operand. `disp_value` equals that digit from the cycle after acceptance.
- R5: In the equals step, code 13 places the result on `disp_value` one cycle after acceptance, and the block returns to the first-digit step. An addition such as 1 plus 3 gives 0x04.
- R6: A subtraction gives first minus second when that difference is not negative. When it would be negative, the result is 0.
- R7: Multiplication gives the product in binary: 5 times 6 gives 0x1E, and 9 times 9 gives 0x51 (81), the largest value the block can produce.
- R8: A key that is not valid for the current step is ignored, and neither the step nor `disp_value` changes. This covers an operator or equals where a digit is expected, a digit or equals where an operator is expected, a digit where equals is expected, and codes 14 and above in any step.
- R9: After a result is shown, a digit key starts a new calculation with that digit as the first operand.
- R10: `key_ready` is high from the second cycle after reset is released. A cycle with `key_valid` low changes neither the step nor `disp_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | A key code is offered |
| key_ready | output | 1 | The block can accept a key |
| key_code | input | 5 | Key code: 0-9 digits, 10 add, 11 subtract, 12 multiply, 13 equals |
| disp_value | output | 8 | Binary value for the display |

## Verification
The display register updates at the clock edge where a key is accepted, so every value is due exactly one cycle after that key is driven. This applies to digits, to the result after equals, and to keys that are ignored, which must leave the value unchanged. The driver pushes each expected value into the scoreboard with a due cycle one greater than the current one. The monitor compares `disp_value` on the falling edge of that due cycle, which is half a cycle after the register has settled and before the next key can act. Reset effects are checked two falling edges after reset is released, once `key_ready` is also expected high.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int DIG_W = 4;
  localparam int NUM_DIGITS = 10;
  localparam int CODE_ADD = 10;
  localparam int CODE_SUB = 11;
  localparam int CODE_MUL = 12;
  localparam int CODE_EQ  = 13;

  typedef enum logic [1:0] {
    STEP_FIRST  = 2'd0,
    STEP_OPER   = 2'd1,
    STEP_SECOND = 2'd2,
    STEP_EQUALS = 2'd3
  } step_t;

  typedef enum logic [1:0] {
    OPR_ADD = 2'd0,
    OPR_SUB = 2'd1,
    OPR_MUL = 2'd2
  } opr_t;

  typedef struct packed {
    logic             is_digit;
    logic             is_opr;
    logic             is_eq;
    logic [DIG_W-1:0] digit;
    opr_t             opr;
  } key_info_t;
endpackage

// File: rtl/calc_key_class.sv
module calc_key_class
  import calc_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic [KEY_W-1:0] code,
  output key_info_t        info
);
  always_comb begin
    info = '0;
    info.opr = OPR_ADD;
    if (int'(code) < NUM_DIGITS) begin
      info.is_digit = 1'b1;
      info.digit    = code[DIG_W-1:0];
    end
    if (int'(code) == CODE_ADD) begin
      info.is_opr = 1'b1;
      info.opr    = OPR_ADD;
    end
    if (int'(code) == CODE_SUB) begin
      info.is_opr = 1'b1;
      info.opr    = OPR_SUB;
    end
    if (int'(code) == CODE_MUL) begin
      info.is_opr = 1'b1;
      info.opr    = OPR_MUL;
    end
    if (int'(code) == CODE_EQ) info.is_eq = 1'b1;
  end
endmodule

// File: rtl/calc_alu.sv
module calc_alu
  import calc_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic [DIG_W-1:0] opa,
  input  logic [DIG_W-1:0] opb,
  input  opr_t             opr,
  output logic [OUT_W-1:0] res
);
  localparam int PW = 2 * DIG_W;

  logic [PW-1:0] sum_w;
  logic [PW-1:0] diff_w;
  logic [PW-1:0] prod_w;
  logic [PW-1:0] pick_w;

  always_comb begin
    sum_w  = PW'(opa) + PW'(opb);
    diff_w = (opa >= opb) ? PW'(opa - opb) : '0;
    prod_w = PW'(opa) * PW'(opb);
    unique case (opr)
      OPR_SUB: pick_w = diff_w;
      OPR_MUL: pick_w = prod_w;
      default: pick_w = sum_w;
    endcase
    res = OUT_W'(pick_w);
  end
endmodule

// File: rtl/calc_seq_fsm.sv
module calc_seq_fsm
  import calc_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  key_info_t        info,
  input  logic [OUT_W-1:0] alu_res,
  output logic [DIG_W-1:0] opa,
  output logic [DIG_W-1:0] opb,
  output opr_t             opr,
  output logic [OUT_W-1:0] disp
);
  localparam int MAX_RES = (NUM_DIGITS - 1) * (NUM_DIGITS - 1);

  step_t step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STEP_FIRST;
      opa    <= '0;
      opb    <= '0;
      opr    <= OPR_ADD;
      disp   <= '0;
    end else if (fire) begin
      unique case (step_q)
        STEP_FIRST: if (info.is_digit) begin
          opa    <= info.digit;
          disp   <= OUT_W'(info.digit);
          step_q <= STEP_OPER;
        end
        STEP_OPER: if (info.is_opr) begin
          opr    <= info.opr;
          step_q <= STEP_SECOND;
        end
        STEP_SECOND: if (info.is_digit) begin
          opb    <= info.digit;
          disp   <= OUT_W'(info.digit);
          step_q <= STEP_EQUALS;
        end
        default: if (info.is_eq) begin
          disp   <= alu_res;
          step_q <= STEP_FIRST;
        end
      endcase
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (disp == '0 && step_q == STEP_FIRST));

  assert_first_digit_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && step_q == STEP_FIRST && info.is_digit) |=>
      disp == OUT_W'($past(info.digit)));

  assert_oper_keeps_disp_R3: assert property (@(posedge clk) disable iff (rst)
    (step_q == STEP_OPER) |=> $stable(disp));

  assert_result_range_R7: assert property (@(posedge clk) disable iff (rst)
    int'(disp) <= MAX_RES);

  assert_bad_first_key_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && step_q == STEP_FIRST && !info.is_digit) |=>
      (step_q == STEP_FIRST && $stable(disp)));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(disp) && $stable(step_q)));
endmodule

// File: rtl/digit_calc_seq.sv
module digit_calc_seq
  import calc_pkg::*;
#(
  parameter int KEY_W = 5,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [KEY_W-1:0] key_code,
  output logic [OUT_W-1:0] disp_value
);
  logic             ready_q;
  logic             fire;
  key_info_t        info;
  logic [DIG_W-1:0] opa;
  logic [DIG_W-1:0] opb;
  opr_t             opr;
  logic [OUT_W-1:0] alu_res;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign key_ready = ready_q;
  assign fire      = key_valid & ready_q;

  calc_key_class #(.KEY_W(KEY_W)) class_i (
    .code (key_code),
    .info (info)
  );

  calc_alu #(.OUT_W(OUT_W)) alu_i (
    .opa (opa),
    .opb (opb),
    .opr (opr),
    .res (alu_res)
  );

  calc_seq_fsm #(.OUT_W(OUT_W)) fsm_i (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .info    (info),
    .alu_res (alu_res),
    .opa     (opa),
    .opb     (opb),
    .opr     (opr),
    .disp    (disp_value)
  );

  assert_ready_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> key_ready);
endmodule

// File: tb/digit_calc_seq_tb_top.sv
module digit_calc_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_valid = 1'b0;
  logic       key_ready;
  logic [4:0] key_code = '0;
  logic [7:0] disp_value;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] exp;
    int         due;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  digit_calc_seq dut_i (
    .clk        (clk),
    .rst        (rst),
    .key_valid  (key_valid),
    .key_ready  (key_ready),
    .key_code   (key_code),
    .disp_value (disp_value)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each expected item on the falling edge of its due cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (disp_value !== it.exp) begin
        fails++;
        $display("FAIL %s: disp_value actual %0d expected %0d", it.tag, disp_value, it.exp);
      end
    end
  end

  task automatic check_now(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input int code, input bit v, input int exp, input string tag);
    item_t it;
    @(negedge clk);
    key_code  = 5'(code);
    key_valid = v;
    it.exp = 8'(exp);
    it.due = cyc + 1;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    key_valid = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    key_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_now(disp_value, 8'd0, "R1 reset display");
    check_now({7'd0, key_ready}, 8'd1, "R10 ready after reset");

    // keys that do not fit the first-digit step
    send(10, 1, 0, "R8 operator in first step");
    send(13, 1, 0, "R8 equals in first step");
    send(15, 1, 0, "R8 code 15");
    // 5 x 6
    send(5, 1, 5, "R2 first digit");
    send(7, 1, 5, "R8 digit in operator step");
    send(12, 1, 5, "R3 multiply keeps display");
    send(12, 1, 5, "R8 operator in second step");
    send(6, 1, 6, "R4 second digit");
    send(3, 1, 6, "R8 digit in equals step");
    send(14, 1, 6, "R8 code 14");
    send(13, 1, 8'h1E, "R7 5x6");
    send(13, 1, 8'h1E, "R8 repeated equals");
    // 1 + 3
    send(1, 1, 1, "R9 new calc first digit");
    send(10, 1, 1, "R3 add keeps display");
    send(3, 1, 3, "R4 second digit 3");
    send(13, 1, 4, "R5 1+3");
    // valid low ignored
    send(4, 0, 4, "R10 valid low ignored");
    // 9 x 9
    send(9, 1, 9, "R9 digit after result");
    send(12, 1, 9, "R3 multiply");
    send(9, 1, 9, "R4 second digit 9");
    send(13, 1, 81, "R7 9x9");
    // 8 - 3
    send(8, 1, 8, "R2 first digit 8");
    send(11, 1, 8, "R3 subtract keeps display");
    send(3, 1, 3, "R4 second digit 3");
    send(13, 1, 5, "R6 8-3");
    // 2 - 7
    send(2, 1, 2, "R2 first digit 2");
    send(11, 1, 2, "R3 subtract");
    send(7, 1, 7, "R4 second digit 7");
    send(13, 1, 0, "R6 negative gives zero");
    // 0 + 9 and 9 + 9
    send(0, 1, 0, "R2 first digit 0");
    send(10, 1, 0, "R3 add");
    send(9, 1, 9, "R4 second digit 9");
    send(13, 1, 9, "R5 0+9");
    send(9, 1, 9, "R9 digit after result");
    send(10, 1, 9, "R3 add");
    send(9, 1, 9, "R4 second digit");
    send(13, 1, 18, "R5 9+9");
    drain();

    // reset in the middle of a calculation
    send(4, 1, 4, "R2 first digit 4");
    send(10, 1, 4, "R3 add");
    drain();
    apply_reset();
    check_now(disp_value, 8'd0, "R1 reset mid calculation");
    send(13, 1, 0, "R1 equals after reset ignored");
    send(2, 1, 2, "R1 first step after reset");
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule